// File: doc/BRIEF.md
# Signed Display Window Offset Unit

This block pans a visible window across a larger virtual drawing area. It takes the raw X and Y beam positions and adds or subtracts a programmable offset to each one. Each axis has its own offset register, which holds a 12-bit magnitude and a sign bit. The host writes these registers through a simple write port, and the block produces a registered effective position for each axis. The result wraps around at the position width, with no clamping.

The read path returns a mixed word. The low bits are the stored offset magnitude, and the top four bits are the upper bits of that axis's raw position. The sign bit cannot be read back. On a write, bit 13 is the sign. On a read, bit 13 is a position bit.

Top module: `window_offset_unit`

## Requirements
- R1: After reset, both offset magnitudes and both signs are zero. A cycle later each effective position equals its raw position, and the read word carries a zero magnitude.
- R2: A write with `wr_en` high stores `wr_data[11:0]` as the magnitude of the axis picked by `wr_axis` (0 selects X, 1 selects Y). Bits 12, 14 and 15 of the write word have no effect.
- R3: A write stores `wr_data[13]` as the sign of the selected axis. Sign 0 makes the effective position equal to raw position plus magnitude. Sign 1 makes it raw position minus magnitude.
- R4: The effective position is computed modulo 2^16. For example, 0xFFFF plus 1 gives 0x0000, and 0x0000 minus 1 gives 0xFFFF.
- R5: `rd_data[11:0]` is the magnitude of the axis picked by `rd_axis`, and `rd_data[15:12]` is bits 15..12 of that axis's raw position. The stored sign never appears in `rd_data`.
- R6: A write to one axis leaves the other axis's magnitude, sign and effective position unchanged.
- R7: Each effective position is registered. It reflects the raw position and the offset present at the previous clock edge, so a write affects the output on the second edge after it is driven.
- R8: `rd_data` is registered. It reflects `rd_axis`, the offset and the raw position sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Offset register write strobe |
| wr_axis | input | 1 | Axis written: 0 = X, 1 = Y |
| wr_data | input | 16 | Write word: bit 13 is the sign, bits 11..0 are the magnitude |
| rd_axis | input | 1 | Axis read: 0 = X, 1 = Y |
| rd_data | output | 16 | Read word: bits 15..12 are the raw position's upper bits, bits 11..0 are the magnitude |
| pos_x_in | input | 16 | Raw X position |
| pos_y_in | input | 16 | Raw Y position |
| pos_x_out | output | 16 | Effective X position |
| pos_y_out | output | 16 | Effective Y position |

## Verification
The sign bit is hard to observe, because it is write-only and bit 13 of the read word shows a position bit instead. The bench therefore infers the sign from the direction of the effective-position shift. It drives raw positions whose bit 13 differs from the written sign, which shows that the read word never carries the sign. Wrap-around is reached by sweeping magnitudes across the full 12-bit range, including 0xFFF and 0x800, against raw positions at 0x0000, 0xFFFF and other points near the wrap. The two axes are always given opposite signs and different magnitudes, so that any crossover between them shows up.

// File: rtl/wofs_pkg.sv
package wofs_pkg;
  localparam int NUM_AXES = 2;
  localparam int AXIS_X   = 0;
  localparam int AXIS_Y   = 1;
  typedef logic axis_sel_t;
endpackage

// File: rtl/wofs_axis_reg.sv
module wofs_axis_reg #(
  parameter int WORD_W   = 16,
  parameter int MAG_W    = 12,
  parameter int SIGN_POS = 13,
  parameter int AXIS_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  wofs_pkg::axis_sel_t wr_axis,
  input  logic [WORD_W-1:0] wr_data,
  output logic [MAG_W-1:0]  mag_q,
  output logic              sign_q
);
  logic hit;
  assign hit = wr_en && (int'(wr_axis) == AXIS_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else if (hit) begin
      mag_q  <= wr_data[MAG_W-1:0];
      sign_q <= wr_data[SIGN_POS];
    end
  end
endmodule

// File: rtl/wofs_adjust.sv
module wofs_adjust #(
  parameter int POS_W = 16,
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos_in,
  input  logic [MAG_W-1:0] mag,
  input  logic             sign,
  output logic [POS_W-1:0] pos_out
);
  localparam int PAD_W = POS_W - MAG_W;

  logic [POS_W-1:0] ext;
  logic [POS_W-1:0] nxt;

  always_comb begin
    ext = {{PAD_W{1'b0}}, mag};
    nxt = sign ? (pos_in - ext) : (pos_in + ext);
  end

  always_ff @(posedge clk) begin
    if (rst) pos_out <= '0;
    else     pos_out <= nxt;
  end
endmodule

// File: rtl/wofs_readback.sv
module wofs_readback #(
  parameter int POS_W   = 16,
  parameter int MAG_W   = 12,
  parameter int UPPER_W = 4,
  parameter int AXES    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wofs_pkg::axis_sel_t        rd_axis,
  input  logic [AXES-1:0][POS_W-1:0] pos_arr,
  input  logic [AXES-1:0][MAG_W-1:0] mag_arr,
  output logic [POS_W-1:0]           rd_data
);
  logic [POS_W-1:0] word;

  always_comb begin
    word = '0;
    word[MAG_W-1:0] = mag_arr[rd_axis];
    word[POS_W-1 -: UPPER_W] = pos_arr[rd_axis][POS_W-1 -: UPPER_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= word;
  end
endmodule

// File: rtl/window_offset_unit.sv
module window_offset_unit #(
  parameter int POS_W    = 16,
  parameter int MAG_W    = 12,
  parameter int SIGN_POS = 13,
  parameter int UPPER_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_axis,
  input  logic [POS_W-1:0] wr_data,
  input  logic             rd_axis,
  output logic [POS_W-1:0] rd_data,
  input  logic [POS_W-1:0] pos_x_in,
  input  logic [POS_W-1:0] pos_y_in,
  output logic [POS_W-1:0] pos_x_out,
  output logic [POS_W-1:0] pos_y_out
);
  localparam int AXES = wofs_pkg::NUM_AXES;

  logic [AXES-1:0][POS_W-1:0] pos_arr;
  logic [AXES-1:0][POS_W-1:0] eff_arr;
  logic [AXES-1:0][MAG_W-1:0] mag_q;
  logic [AXES-1:0]            sign_q;

  assign pos_arr[wofs_pkg::AXIS_X] = pos_x_in;
  assign pos_arr[wofs_pkg::AXIS_Y] = pos_y_in;
  assign pos_x_out = eff_arr[wofs_pkg::AXIS_X];
  assign pos_y_out = eff_arr[wofs_pkg::AXIS_Y];

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    wofs_axis_reg #(
      .WORD_W(POS_W), .MAG_W(MAG_W), .SIGN_POS(SIGN_POS), .AXIS_ID(a)
    ) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_axis(wr_axis),
      .wr_data(wr_data), .mag_q(mag_q[a]), .sign_q(sign_q[a])
    );

    wofs_adjust #(.POS_W(POS_W), .MAG_W(MAG_W)) u_adj (
      .clk(clk), .rst(rst), .pos_in(pos_arr[a]), .mag(mag_q[a]),
      .sign(sign_q[a]), .pos_out(eff_arr[a])
    );
  end

  wofs_readback #(
    .POS_W(POS_W), .MAG_W(MAG_W), .UPPER_W(UPPER_W), .AXES(AXES)
  ) u_rb (
    .clk(clk), .rst(rst), .rd_axis(rd_axis), .pos_arr(pos_arr),
    .mag_arr(mag_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/wofs_checker.sv
module wofs_checker #(
  parameter int POS_W    = 16,
  parameter int MAG_W    = 12,
  parameter int SIGN_POS = 13,
  parameter int UPPER_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_axis,
  input logic [POS_W-1:0] wr_data,
  input logic             rd_axis,
  input logic [POS_W-1:0] rd_data,
  input logic [POS_W-1:0] pos_x_in,
  input logic [POS_W-1:0] pos_y_in,
  input logic [POS_W-1:0] pos_x_out,
  input logic [POS_W-1:0] pos_y_out,
  input logic [1:0][MAG_W-1:0] mag_q,
  input logic [1:0]       sign_q
);
  // R1: registers cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (mag_q == '0 && sign_q == '0));

  // R2: X write captures the low magnitude field
  assert_write_mag_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(wr_axis)) |->
      mag_q[0] == $past(wr_data[MAG_W-1:0]));

  // R3: Y write captures the sign bit
  assert_write_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_axis)) |->
      sign_q[1] == $past(wr_data[SIGN_POS]));

  // R3, R4, R7: X output shift equals previous offset, modulo width
  assert_x_shift_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (($past(sign_q[0]) ? POS_W'($past(pos_x_in) - pos_x_out)
                         : POS_W'(pos_x_out - $past(pos_x_in)))
        == POS_W'($past(mag_q[0]))));

  assert_y_shift_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (($past(sign_q[1]) ? POS_W'($past(pos_y_in) - pos_y_out)
                         : POS_W'(pos_y_out - $past(pos_y_in)))
        == POS_W'($past(mag_q[1]))));

  // R5, R8: read word fields
  assert_read_mag_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data[MAG_W-1:0] == $past(mag_q[rd_axis]));

  assert_read_upper_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data[POS_W-1 -: UPPER_W] ==
      $past(rd_axis ? pos_y_in[POS_W-1 -: UPPER_W] : pos_x_in[POS_W-1 -: UPPER_W]));

  // R6: untouched axis keeps its offset
  assert_axis_isolated_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(wr_axis)) |->
      (mag_q[1] == $past(mag_q[1]) && sign_q[1] == $past(sign_q[1])));
endmodule

bind window_offset_unit wofs_checker #(
  .POS_W(POS_W), .MAG_W(MAG_W), .SIGN_POS(SIGN_POS), .UPPER_W(UPPER_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_axis(wr_axis), .wr_data(wr_data),
  .rd_axis(rd_axis), .rd_data(rd_data), .pos_x_in(pos_x_in),
  .pos_y_in(pos_y_in), .pos_x_out(pos_x_out), .pos_y_out(pos_y_out),
  .mag_q(mag_q), .sign_q(sign_q)
);

// File: tb/sim_window_offset_unit.sv
`timescale 1ns/1ps
module sim_window_offset_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_axis = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_axis = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] pos_x_in = '0;
  logic [15:0] pos_y_in = '0;
  logic [15:0] pos_x_out;
  logic [15:0] pos_y_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  window_offset_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_axis(wr_axis), .wr_data(wr_data),
    .rd_axis(rd_axis), .rd_data(rd_data), .pos_x_in(pos_x_in),
    .pos_y_in(pos_y_in), .pos_x_out(pos_x_out), .pos_y_out(pos_y_out)
  );

  function automatic logic [15:0] eff(logic [15:0] p, logic [11:0] m, logic s);
    return s ? 16'(p - {4'b0, m}) : 16'(p + {4'b0, m});
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic ax, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_axis = ax; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drive(logic [15:0] px, logic [15:0] py, logic ra);
    pos_x_in = px; pos_y_in = py; rd_axis = ra;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pv [6];
    pv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h2ABC, 16'hD00F};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data in reset", rd_data, 16'h0000);
    check("R1 pos_x_out in reset", pos_x_out, 16'h0000);
    rst = 1'b0;
    drive(16'h1234, 16'hBEEF, 1'b1);
    check("R1 x passthrough", pos_x_out, 16'h1234);
    check("R1 y passthrough", pos_y_out, 16'hBEEF);
    check("R1 rd zero magnitude", rd_data, 16'hB000);

    // R4: explicit wrap both directions
    wr(1'b0, 16'h0001);
    wr(1'b1, 16'h2001);
    drive(16'hFFFF, 16'h0000, 1'b0);
    check("R4 x wraps up", pos_x_out, 16'h0000);
    check("R4 y wraps down", pos_y_out, 16'hFFFF);

    // R2, R5: ignored bits 15,14,12 ; sign not in read word (pos bit13 = 0)
    wr(1'b0, 16'hF5A5);
    drive(16'h0100, 16'h0000, 1'b0);
    check("R2 ignored bits, mag readback", rd_data, 16'h05A5);
    check("R3 sign from bit13 subtracts", pos_x_out, 16'(16'h0100 - 16'h05A5));
    // R5: raw position bit 13 = 1 while sign = 0 on Y
    wr(1'b1, 16'h0123);
    drive(16'h0000, 16'h2000, 1'b1);
    check("R5 rd upper from position", rd_data, 16'h2123);

    // R7: write effect delayed one cycle at output
    drive(16'h4000, 16'h4000, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_axis = 1'b0; wr_data = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 old offset still at output", pos_x_out, 16'(16'h4000 - 16'h05A5));
    @(negedge clk);
    check("R7 new offset at output", pos_x_out, 16'h4010);
    check("R6 y unaffected by x write", pos_y_out, 16'h4123);

    // R8: rd_axis change visible only after edge
    rd_axis = 1'b1;
    #1;
    check("R8 rd_data holds before edge", rd_data, 16'h4010);
    @(negedge clk);
    check("R8 rd_data after edge", rd_data, 16'h4123);

    // R3, R4, R6: sweep magnitudes, signs, positions
    for (int mi = 0; mi < 48; mi++) begin
      for (int s = 0; s < 2; s++) begin
        logic [11:0] mx, my;
        logic sx, sy;
        mx = (mi == 0) ? 12'h000 : (mi == 1) ? 12'hFFF : (mi == 2) ? 12'h800 : 12'(mi * 181);
        my = ~mx;
        sx = s[0];
        sy = ~s[0];
        wr(1'b0, {2'b11, sx, 1'b1, mx});
        wr(1'b1, {2'b00, sy, 1'b0, my});
        for (int pi = 0; pi < 6; pi++) begin
          logic [15:0] px, py;
          px = pv[pi];
          py = ~pv[pi] ^ 16'h2000;
          drive(px, py, pi[0]);
          check("R3 sweep x", pos_x_out, eff(px, mx, sx));
          check("R6 sweep y", pos_y_out, eff(py, my, sy));
          check("R5 sweep read", rd_data,
                pi[0] ? {py[15:12], my} : {px[15:12], mx});
        end
      end
    end

    // R1: reset again clears offsets
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(16'h7777, 16'h8888, 1'b0);
    check("R1 x after reset", pos_x_out, 16'h7777);
    check("R1 read after reset", rd_data, 16'h7000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule